// File: doc/BRIEF.md
# Memory-Type Range Invalidation Address Generator

When software rewrites one of the registers that decide the cached memory type of guest physical memory, every translation built under the old type in the affected region must be dropped. This block takes the address of the register just written, together with the register values now in force, and works out the exact guest physical window whose type may have changed. It hands that window to a downstream invalidation engine as a start and an end page frame number. The end is exclusive.

Each register class has its own window rule. The fixed-range registers cover set slices of the first megabyte. The default-type register covers the whole space. A variable base/mask pair covers the power-of-two region that its base and mask describe, limited by the physical address width. The block does not validate the write and does not perform the invalidation.

Results leave through a valid-only stream with no ready. The consumer must take a range in the cycle `rng_valid` is high, so no back-pressure is possible. A new write may arrive in every cycle, and each one yields at most one range, one cycle later.

Top module: `inval_range_gen`

## Requirements
- R1: A write to the page-attribute register (address 0x51), or any write while `feature_on` is low, produces no range.
- R2: When the global enable bit (bit 11 of `def_type`) is clear, no range is produced unless the write targeted the default-type register (address 0x50).
- R3: A write to address 0x40 yields the range 0x0–0x80000. A write to 0x41 yields 0x80000–0xA0000. A write to 0x42 yields 0xA0000–0xC0000.
- R4: A write to address 0x48+i (i = 0..7) yields the range from 0xC0000 + i·0x8000 to that value plus 0x8000.
- R5: When the fixed-range enable bit (bit 10 of `def_type`) is clear, writes to addresses 0x40–0x42 and 0x48–0x4F produce no range.
- R6: A write to the default-type register yields start 0 and end all-ones in the address space.
- R7: A write to variable address 2p or 2p+1 (p < NUM_VAR; an even address holds the base, an odd address holds the mask) yields a range computed as follows. Start is `var_base` with bits 11:0 cleared. M is `var_mask` with bits 11:0 cleared and every bit at or above `paw` set. End is ((start AND M) OR NOT M) + 1, taken modulo 2^DATA_W.
- R8: Start and end are presented as page frame numbers, which are the DATA_W-bit addresses shifted right by 12.
- R9: After reset `rng_valid` is low. A write accepted on one clock edge drives `rng_valid` high for exactly the following cycle, with the range on the data pins in that cycle.
- R10: A write to any other address produces no range. This includes variable addresses at or beyond 2·NUM_VAR, and 0x43–0x47 and 0x52 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A register write was accepted this cycle |
| wr_addr | input | REG_AW | Address of the written register |
| feature_on | input | 1 | Translation on and non-coherent DMA present |
| def_type | input | DATA_W | Current default-type value (bit 11 enable, bit 10 fixed enable) |
| var_base | input | DATA_W | Current base of the variable pair addressed |
| var_mask | input | DATA_W | Current mask of the variable pair addressed |
| paw | input | PAW_W | Physical address width in bits |
| rng_valid | output | 1 | Range strobe, high for one cycle |
| rng_start_pfn | output | DATA_W-12 | First page frame of the range |
| rng_end_pfn | output | DATA_W-12 | Page frame just past the range |

## Verification
Every range is due in the cycle after the edge on which its write was sampled. No result takes longer than that one register stage. The bench drives each write on a falling edge and pushes the expected range into a queue at that moment. A monitor samples the outputs on the next falling edge, which is half a cycle after the result edge. For writes that must stay silent, the driver checks `rng_valid` on that same falling edge. Any range that appears with an empty queue counts as a mismatch, so an extra or late pulse is caught as well as a missing one.

// File: rtl/inval_range_gen_pkg.sv
package inval_range_gen_pkg;

  typedef enum logic [2:0] {
    CL_NONE = 3'd0,
    CL_PAT  = 3'd1,
    CL_DEF  = 3'd2,
    CL_FIX  = 3'd3,
    CL_VAR  = 3'd4
  } reg_class_e;

  localparam logic [7:0] ADDR_FIX64  = 8'h40;
  localparam logic [7:0] ADDR_FIX16A = 8'h41;
  localparam logic [7:0] ADDR_FIX16B = 8'h42;
  localparam logic [7:0] ADDR_FIX4K  = 8'h48;  // 0x48..0x4F
  localparam logic [7:0] ADDR_DEF    = 8'h50;
  localparam logic [7:0] ADDR_PAT    = 8'h51;

  localparam int EN_BIT  = 11;
  localparam int FEN_BIT = 10;

  // fixed window slot: 0 = 64K, 1..2 = 16K, 3..10 = 4K
  localparam int FIX_SLOTS = 11;

endpackage

// File: rtl/inval_range_decode.sv
module inval_range_decode
  import inval_range_gen_pkg::*;
#(
  parameter int REG_AW  = 8,
  parameter int NUM_VAR = 8
) (
  input  logic [REG_AW-1:0] addr,
  output reg_class_e        cls,
  output logic [3:0]        fix_slot
);
  localparam int VAR_TOP = 2 * NUM_VAR;

  always_comb begin
    cls      = CL_NONE;
    fix_slot = 4'd0;
    if (int'(addr) < VAR_TOP) begin
      cls = CL_VAR;
    end else if (addr == REG_AW'(ADDR_DEF)) begin
      cls = CL_DEF;
    end else if (addr == REG_AW'(ADDR_PAT)) begin
      cls = CL_PAT;
    end else if (addr == REG_AW'(ADDR_FIX64)) begin
      cls      = CL_FIX;
      fix_slot = 4'd0;
    end else if (addr == REG_AW'(ADDR_FIX16A)) begin
      cls      = CL_FIX;
      fix_slot = 4'd1;
    end else if (addr == REG_AW'(ADDR_FIX16B)) begin
      cls      = CL_FIX;
      fix_slot = 4'd2;
    end else if ((addr >> 3) == REG_AW'(ADDR_FIX4K >> 3)) begin
      cls      = CL_FIX;
      fix_slot = 4'd3 + {1'b0, addr[2:0]};
    end
  end
endmodule

// File: rtl/inval_fixed_window.sv
module inval_fixed_window #(
  parameter int DATA_W = 64
) (
  input  logic [3:0]        slot,
  output logic [DATA_W-1:0] win_start,
  output logic [DATA_W-1:0] win_end
);
  localparam int NARROW_W = 21;  // 0x100000 fits in 21 bits

  logic [NARROW_W-1:0] s_n, e_n;

  always_comb begin
    unique case (slot)
      4'd0: begin s_n = 21'h00000; e_n = 21'h80000; end
      4'd1: begin s_n = 21'h80000; e_n = 21'hA0000; end
      4'd2: begin s_n = 21'hA0000; e_n = 21'hC0000; end
      default: begin
        s_n = 21'hC0000 + ({17'd0, slot - 4'd3} << 15);
        e_n = s_n + 21'h08000;
      end
    endcase
  end

  assign win_start = DATA_W'(s_n);
  assign win_end   = DATA_W'(e_n);
endmodule

// File: rtl/inval_var_window.sv
module inval_var_window #(
  parameter int DATA_W  = 64,
  parameter int PAGE_SH = 12,
  parameter int PAW_W   = 7
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] mask,
  input  logic [PAW_W-1:0]  paw,
  output logic [DATA_W-1:0] win_start,
  output logic [DATA_W-1:0] win_end
);
  localparam logic [DATA_W-1:0] PAGE_KEEP =
    {{(DATA_W-PAGE_SH){1'b1}}, {PAGE_SH{1'b0}}};

  logic [DATA_W-1:0] above_paw;
  logic [DATA_W-1:0] eff_mask;

  for (genvar b = 0; b < DATA_W; b++) begin : g_hi
    localparam logic [PAW_W:0] BIT_POS = (PAW_W+1)'(b);
    assign above_paw[b] = ({1'b0, paw} <= BIT_POS);
  end

  assign win_start = base & PAGE_KEEP;
  assign eff_mask  = (mask & PAGE_KEEP) | above_paw;
  assign win_end   = ((win_start & eff_mask) | ~eff_mask) + DATA_W'(1);
endmodule

// File: rtl/inval_range_gen.sv
module inval_range_gen
  import inval_range_gen_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int PAGE_SH = 12,
  parameter int REG_AW  = 8,
  parameter int NUM_VAR = 8,
  parameter int PAW_W   = 7,
  localparam int PFN_W  = DATA_W - PAGE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic              feature_on,
  input  logic [DATA_W-1:0] def_type,
  input  logic [DATA_W-1:0] var_base,
  input  logic [DATA_W-1:0] var_mask,
  input  logic [PAW_W-1:0]  paw,
  output logic              rng_valid,
  output logic [PFN_W-1:0]  rng_start_pfn,
  output logic [PFN_W-1:0]  rng_end_pfn
);
  reg_class_e        cls;
  logic [3:0]        fix_slot;
  logic [DATA_W-1:0] fix_s, fix_e, var_s, var_e;
  logic [DATA_W-1:0] sel_s, sel_e;
  logic              en_all, en_fix, emit;

  inval_range_decode #(.REG_AW(REG_AW), .NUM_VAR(NUM_VAR)) u_dec (
    .addr     (wr_addr),
    .cls      (cls),
    .fix_slot (fix_slot)
  );

  inval_fixed_window #(.DATA_W(DATA_W)) u_fix (
    .slot      (fix_slot),
    .win_start (fix_s),
    .win_end   (fix_e)
  );

  inval_var_window #(.DATA_W(DATA_W), .PAGE_SH(PAGE_SH), .PAW_W(PAW_W)) u_var (
    .base      (var_base),
    .mask      (var_mask),
    .paw       (paw),
    .win_start (var_s),
    .win_end   (var_e)
  );

  assign en_all = def_type[EN_BIT];
  assign en_fix = def_type[FEN_BIT];

  always_comb begin
    emit  = 1'b0;
    sel_s = '0;
    sel_e = '0;
    if (wr_valid && feature_on) begin
      unique case (cls)
        CL_DEF: begin
          emit  = 1'b1;
          sel_e = '1;
        end
        CL_FIX: begin
          emit  = en_all && en_fix;
          sel_s = fix_s;
          sel_e = fix_e;
        end
        CL_VAR: begin
          emit  = en_all;
          sel_s = var_s;
          sel_e = var_e;
        end
        default: emit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_valid     <= 1'b0;
      rng_start_pfn <= '0;
      rng_end_pfn   <= '0;
    end else begin
      rng_valid <= emit;
      if (emit) begin
        rng_start_pfn <= sel_s[DATA_W-1:PAGE_SH];
        rng_end_pfn   <= sel_e[DATA_W-1:PAGE_SH];
      end
    end
  end
endmodule

// File: rtl/inval_range_gen_chk.sv
module inval_range_gen_chk
  import inval_range_gen_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int PAGE_SH = 12,
  parameter int REG_AW  = 8,
  parameter int PAW_W   = 7,
  localparam int PFN_W  = DATA_W - PAGE_SH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [REG_AW-1:0] wr_addr,
  input logic              feature_on,
  input logic [DATA_W-1:0] def_type,
  input logic [DATA_W-1:0] var_base,
  input logic [DATA_W-1:0] var_mask,
  input logic [PAW_W-1:0]  paw,
  input logic              rng_valid,
  input logic [PFN_W-1:0]  rng_start_pfn,
  input logic [PFN_W-1:0]  rng_end_pfn
);
  assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rng_valid |-> $past(wr_valid));

  assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (!feature_on || wr_addr == REG_AW'(ADDR_PAT))) |=> !rng_valid);

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !def_type[EN_BIT] && wr_addr != REG_AW'(ADDR_DEF)) |=> !rng_valid);

  assert_fix_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !def_type[FEN_BIT] && wr_addr >= REG_AW'(ADDR_FIX64)
     && wr_addr < REG_AW'(ADDR_DEF)) |=> !rng_valid);

  assert_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && feature_on && wr_addr == REG_AW'(ADDR_DEF))
    |=> (rng_valid && rng_start_pfn == '0 && rng_end_pfn == '1));

  assert_low64k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && feature_on && def_type[EN_BIT] && def_type[FEN_BIT]
     && wr_addr == REG_AW'(ADDR_FIX64))
    |=> (rng_valid && rng_start_pfn == '0 && rng_end_pfn == PFN_W'(8'h80)));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr > REG_AW'(ADDR_PAT)) |=> !rng_valid);
endmodule

bind inval_range_gen inval_range_gen_chk #(
  .DATA_W(DATA_W), .PAGE_SH(PAGE_SH), .REG_AW(REG_AW), .PAW_W(PAW_W)
) u_chk (.*);

// File: tb/inval_range_gen_bench.sv
module inval_range_gen_bench;
  localparam int DATA_W  = 64;
  localparam int PAGE_SH = 12;
  localparam int REG_AW  = 8;
  localparam int NUM_VAR = 8;
  localparam int PAW_W   = 7;
  localparam int PFN_W   = DATA_W - PAGE_SH;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [REG_AW-1:0] wr_addr = '0;
  logic              feature_on = 1'b0;
  logic [DATA_W-1:0] def_type = '0;
  logic [DATA_W-1:0] var_base = '0;
  logic [DATA_W-1:0] var_mask = '0;
  logic [PAW_W-1:0]  paw = '0;
  logic              rng_valid;
  logic [PFN_W-1:0]  rng_start_pfn, rng_end_pfn;

  always #2 clk = ~clk;  // 250 MHz

  inval_range_gen u_inval_range_gen (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic [2*PFN_W-1:0] exp_q[$];
  string tag_q[$];

  localparam logic [DATA_W-1:0] EN  = 64'h800;
  localparam logic [DATA_W-1:0] FEN = 64'h400;

  // Expected range from the requirement text alone
  task automatic model(input logic [REG_AW-1:0] a, output bit prod,
                       output logic [DATA_W-1:0] s, output logic [DATA_W-1:0] e);
    logic [DATA_W-1:0] m;
    prod = 0; s = '0; e = '0;
    if (!feature_on || a == 8'h51) return;                       // R1
    if (a == 8'h50) begin prod = 1; e = '1; return; end            // R6
    if (!def_type[11]) return;                                     // R2
    if (a == 8'h40 || a == 8'h41 || a == 8'h42 || (a >= 8'h48 && a <= 8'h4F)) begin
      if (!def_type[10]) return;                                   // R5
      prod = 1;
      if (a == 8'h40) begin s = 0; e = 64'h80000; end
      else if (a == 8'h41) begin s = 64'h80000; e = 64'hA0000; end
      else if (a == 8'h42) begin s = 64'hA0000; e = 64'hC0000; end
      else begin s = 64'hC0000 + 64'(a - 8'h48) * 64'h8000; e = s + 64'h8000; end
      return;
    end
    if (a < 2 * NUM_VAR) begin                                     // R7
      prod = 1;
      s = var_base & ~64'hFFF;
      m = var_mask & ~64'hFFF;
      for (int b = 0; b < DATA_W; b++) if (b >= int'(paw)) m[b] = 1'b1;
      e = ((s & m) | ~m) + 64'd1;
    end
  endtask

  task automatic do_write(input logic [REG_AW-1:0] a, input string tag);
    bit prod;
    logic [DATA_W-1:0] s, e;
    @(negedge clk);
    wr_addr  = a;
    wr_valid = 1'b1;
    model(a, prod, s, e);
    if (prod) begin
      exp_q.push_back({s[DATA_W-1:PAGE_SH], e[DATA_W-1:PAGE_SH]});    // R8
      tag_q.push_back(tag);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    if (!prod) begin
      n_cmp++;
      if (rng_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL %s: rng_valid=%b expected 0", tag, rng_valid);
      end
    end
  endtask

  // Monitor: every pulse must match the oldest expected range
  always @(negedge clk) begin
    if (rst_n && rng_valid === 1'b1) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9: unexpected range %h..%h expected none", rng_start_pfn, rng_end_pfn);
      end else begin
        logic [2*PFN_W-1:0] x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rng_start_pfn, rng_end_pfn} !== x) begin
          n_bad++;
          $display("FAIL %s: got %h..%h expected %h..%h", t, rng_start_pfn, rng_end_pfn,
                   x[2*PFN_W-1:PFN_W], x[PFN_W-1:0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (rng_valid !== 1'b0 || rng_start_pfn !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: valid=%b start=%h expected 0/0", rng_valid, rng_start_pfn);
    end
    rst_n = 1'b1;
    feature_on = 1'b1;
    def_type = EN | FEN | 64'h6;
    paw = 7'd36;

    do_write(8'h40, "R3 64K");
    do_write(8'h41, "R3 16K low");
    do_write(8'h42, "R3 16K high");
    for (int i = 0; i < 8; i++) do_write(8'h48 + 8'(i), "R4 4K slot");
    do_write(8'h50, "R6 default");

    var_base = 64'h0000_0001_2345_6006;
    var_mask = 64'h0000_000F_FFF0_0800;
    do_write(8'h00, "R7 var base pair0");
    do_write(8'h0F, "R7 var mask pair7");
    paw = 7'd40;
    var_base = 64'h0000_00AB_CDEF_1006;
    var_mask = 64'h0000_00FF_FFFF_F800;
    do_write(8'h05, "R7 var 4K region");
    paw = 7'd64;
    var_mask = 64'h0;
    do_write(8'h02, "R8 var full wrap");

    // back-to-back writes then idle: each pulse single-cycle
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'h41;
    exp_q.push_back({52'h80, 52'hA0}); tag_q.push_back("R9 b2b first");
    @(negedge clk);
    wr_addr = 8'h42;
    exp_q.push_back({52'hA0, 52'hC0}); tag_q.push_back("R9 b2b second");
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (rng_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: pulse held, valid=%b expected 0", rng_valid);
    end

    do_write(8'h51, "R1 page-attr");
    feature_on = 1'b0;
    do_write(8'h50, "R1 feature off default");
    do_write(8'h40, "R1 feature off fixed");
    feature_on = 1'b1;
    do_write(8'h10, "R10 var beyond count");
    do_write(8'h45, "R10 hole");
    do_write(8'h60, "R10 high");
    def_type = EN | 64'h6;
    do_write(8'h48, "R5 fixed off 4K");
    do_write(8'h40, "R5 fixed off 64K");
    do_write(8'h03, "R5 var still active");
    def_type = FEN;
    do_write(8'h03, "R2 disabled var");
    do_write(8'h42, "R2 disabled fixed");
    do_write(8'h50, "R2 disabled default still emits");

    repeat (3) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9: %0d ranges missing expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule